// File: doc/BRIEF.md
# Crossbar Clock Generator Channel

This block forms one output channel of a programmable clock generator. A crossbar picks one of up to 64 reference clocks. The picked clock passes through a gate and a 10-bit pre-divider, then through a second gate and a 6-bit final divider, and leaves as `clk_out`. The output rate is the reference rate divided by both ratios in cascade.

Software sets up the channel through a small 32-bit register interface that runs on `clk`. The source select and the pre-divider gate sit in an 8-bit lane of a crossbar register that four channels share. Each divider ratio has a register of its own, and the final-divider gate sits in the final ratio register. Two command pulses give the enable and disable sequence. Enable opens both gates. Disable closes only the final gate, so the pre-divider keeps running. The channel counts as enabled exactly when the final gate bit is set.

The block has no data stream, so it has no valid/ready interface. Every pin is a plain control or status signal. A write takes effect on the `clk` edge where `reg_wr` is high, and it cannot be refused. Reads are combinational on `reg_addr`. Gate and ratio changes cross into the divided clock domains through two-stage synchronisers. A new ratio is loaded only at the end of an output period, and each gate closes or opens only while its clock is low.

Top module: `fgc_channel`

## Requirements
- R1: After reset, all three channel registers read zero, `ch_enabled` is 0, and `clk_out` is low and shows no edges.
- R2: The crossbar register is at byte address 0x18 + 4*floor(CH_IDX/4). The channel's lane starts at bit L = (CH_IDX mod 4)*8. Bits L..L+5 hold the source select and bit L+6 holds the pre-divider gate. All other bits read 0, and writes to them are ignored.
- R3: The pre-divider ratio register is at 0x58 + 4*CH_IDX. Bits 9:0 hold the ratio and the upper bits read 0.
- R4: The final register is at 0x164 + 4*CH_IDX. Bits 5:0 hold the final ratio and bit 6 holds the final gate. The upper bits read 0.
- R5: When both gates are open, the `clk_out` period equals the selected source period times (P+1)*(F+1), where P and F are the ratio fields. A field of 0 passes the clock through.
- R6: A select value s routes `ref_clk[s]` into the pre-divider.
- R7: A `cmd_enable` pulse sets both gate bits on the next `clk` edge. A `cmd_disable` pulse clears only the final gate bit. When both pulses arrive together, the final gate ends cleared and the pre gate ends set. Clearing the pre gate also stops the output.
- R8: `ch_enabled` equals the final gate bit at all times, whatever the state of the pre gate.
- R9: Once the final gate is closed, `clk_out` shows no further edges. While it is open, no phase of `clk_out` is shorter than the smallest source half-period (no runt pulses).
- R10: Writes to any other address change no channel state, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | NUM_SRC | Reference clock inputs to the crossbar |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Byte address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| cmd_enable | input | 1 | Pulse that opens both gates |
| cmd_disable | input | 1 | Pulse that closes the final gate |
| ch_enabled | output | 1 | High while the final gate bit is set |
| clk_out | output | 1 | Channel output clock |

## Verification
A wrong select or a wrong ratio shows up as a wrong rise-to-rise period of `clk_out`. This appears a few output periods after the change, once the synchronisers and the current period have run out. A gate bit held in the wrong state appears on `ch_enabled` or in the register readback one `clk` cycle after the command. A gate that fails to close leaves edges on `clk_out` within a few source cycles. A gate or ratio switch that is not glitch-free shows up as an output phase shorter than any source half-period.

// File: rtl/fgc_pkg.sv
`timescale 1ns/1ps
package fgc_pkg;
  // Register interface geometry
  localparam int unsigned REG_W         = 32;
  localparam int unsigned LANE_W        = 8;
  localparam int unsigned LANES_PER_REG = 4;
  localparam int unsigned SLOT_STRIDE   = 4;

  // Field widths
  localparam int unsigned SEL_W   = 6;
  localparam int unsigned PDIV_W  = 10;
  localparam int unsigned FDIV_W  = 6;

  // Gate bit positions (pre gate is relative to the lane)
  localparam int unsigned PGATE_POS = 6;
  localparam int unsigned FGATE_POS = 6;

  // Bank base addresses
  localparam int unsigned XBAR_BASE = 'h018;
  localparam int unsigned PDIV_BASE = 'h058;
  localparam int unsigned FDIV_BASE = 'h164;

  typedef enum logic [1:0] {
    RS_NONE,
    RS_XBAR,
    RS_PDIV,
    RS_FDIV
  } rsel_e;
endpackage

// File: rtl/fgc_regs.sv
`timescale 1ns/1ps
module fgc_regs
  import fgc_pkg::*;
#(
  parameter int unsigned CH_IDX = 0,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = REG_W,
  parameter int unsigned PRE_W  = PDIV_W,
  parameter int unsigned FIN_W  = FDIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cmd_enable,
  input  logic              cmd_disable,
  output logic [SEL_W-1:0]  sel,
  output logic              pre_gate,
  output logic [PRE_W-1:0]  pre_ratio,
  output logic              fin_gate,
  output logic [FIN_W-1:0]  fin_ratio
);
  localparam int unsigned LANE_LSB = (CH_IDX % LANES_PER_REG) * LANE_W;
  localparam int unsigned PG_BIT   = LANE_LSB + PGATE_POS;
  localparam logic [ADDR_W-1:0] XBAR_A =
    ADDR_W'(XBAR_BASE + (CH_IDX / LANES_PER_REG) * SLOT_STRIDE);
  localparam logic [ADDR_W-1:0] PDIV_A = ADDR_W'(PDIV_BASE + CH_IDX * SLOT_STRIDE);
  localparam logic [ADDR_W-1:0] FDIV_A = ADDR_W'(FDIV_BASE + CH_IDX * SLOT_STRIDE);

  rsel_e             rsel;
  logic [SEL_W-1:0]  sel_q;
  logic              pgate_q;
  logic [PRE_W-1:0]  pdiv_q;
  logic              fgate_q;
  logic [FIN_W-1:0]  fdiv_q;

  // Address decode shared by read and write
  always_comb begin
    if (reg_addr == XBAR_A)      rsel = RS_XBAR;
    else if (reg_addr == PDIV_A) rsel = RS_PDIV;
    else if (reg_addr == FDIV_A) rsel = RS_FDIV;
    else                         rsel = RS_NONE;
  end

  // Register writes first, then the command pulses (disable wins on the final gate)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      pgate_q <= 1'b0;
      pdiv_q  <= '0;
      fgate_q <= 1'b0;
      fdiv_q  <= '0;
    end else begin
      if (reg_wr) begin
        case (rsel)
          RS_XBAR: begin
            sel_q   <= reg_wdata[LANE_LSB +: SEL_W];
            pgate_q <= reg_wdata[PG_BIT];
          end
          RS_PDIV: pdiv_q <= reg_wdata[PRE_W-1:0];
          RS_FDIV: begin
            fdiv_q  <= reg_wdata[FIN_W-1:0];
            fgate_q <= reg_wdata[FGATE_POS];
          end
          default: ;
        endcase
      end
      if (cmd_enable) begin
        pgate_q <= 1'b1;
        fgate_q <= 1'b1;
      end
      if (cmd_disable) fgate_q <= 1'b0;
    end
  end

  // Readback: unused bits are zero
  always_comb begin
    reg_rdata = '0;
    case (rsel)
      RS_XBAR: begin
        reg_rdata[LANE_LSB +: SEL_W] = sel_q;
        reg_rdata[PG_BIT]            = pgate_q;
      end
      RS_PDIV: reg_rdata[PRE_W-1:0] = pdiv_q;
      RS_FDIV: begin
        reg_rdata[FIN_W-1:0] = fdiv_q;
        reg_rdata[FGATE_POS] = fgate_q;
      end
      default: ;
    endcase
  end

  wire unused_wdata = ^reg_wdata;

  assign sel       = sel_q;
  assign pre_gate  = pgate_q;
  assign pre_ratio = pdiv_q;
  assign fin_gate  = fgate_q;
  assign fin_ratio = fdiv_q;
endmodule

// File: rtl/fgc_xbar.sv
`timescale 1ns/1ps
module fgc_xbar
  import fgc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0] ref_clk,
  input  logic [SEL_W-1:0]   sel,
  output logic               clk_sel
);
  localparam int unsigned SPAN = 1 << SEL_W;

  logic [SPAN-1:0] src_pad;

  // Unpopulated select codes route a constant low
  generate
    if (NUM_SRC >= SPAN) begin : g_full
      assign src_pad = ref_clk[SPAN-1:0];
    end else begin : g_pad
      assign src_pad = {{(SPAN-NUM_SRC){1'b0}}, ref_clk};
    end
  endgenerate

  assign clk_sel = src_pad[sel];
endmodule

// File: rtl/fgc_icg.sv
`timescale 1ns/1ps
module fgc_icg #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic en_async,
  output logic clk_gated
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   en_lat;

  // Bring the enable into the clk_in domain
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], en_async};
  end

  // Transparent only while clk_in is low: the gate never cuts a high phase
  always_latch begin
    if (!rst_n)      en_lat = 1'b0;
    else if (!clk_in) en_lat = sync_q[SYNC_STAGES-1];
  end

  assign clk_gated = clk_in & en_lat;
endmodule

// File: rtl/fgc_div.sv
`timescale 1ns/1ps
module fgc_div #(
  parameter int unsigned W = 10
) (
  input  logic         clk_in,
  input  logic         rst_n,
  input  logic [W-1:0] ratio_async,
  output logic         clk_div
);
  logic [W-1:0] r_s1, r_s2;
  logic [W-1:0] cur_n;
  logic [W-1:0] cnt;
  logic         hi;
  logic [W:0]   high_len;
  logic [W:0]   cnt_nxt;
  logic         at_end;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      r_s1 <= '0;
      r_s2 <= '0;
    end else begin
      r_s1 <= ratio_async;
      r_s2 <= r_s1;
    end
  end

  // High phase covers ceil((n+1)/2) input cycles
  assign high_len = ({1'b0, cur_n} + (W+1)'(2)) >> 1;
  assign cnt_nxt  = {1'b0, cnt} + (W+1)'(1);
  assign at_end   = (cnt >= cur_n);

  // Ratio reloads only at a period boundary
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      cur_n <= '0;
      hi    <= 1'b1;
    end else if (at_end) begin
      cnt   <= '0;
      cur_n <= r_s2;
      hi    <= 1'b1;
    end else begin
      cnt   <= cnt_nxt[W-1:0];
      hi    <= (cnt_nxt < high_len);
    end
  end

  // Ratio zero bypasses the counter; the switch lands on a rising edge
  assign clk_div = (cur_n == '0) ? clk_in : hi;
endmodule

// File: rtl/fgc_channel.sv
`timescale 1ns/1ps
module fgc_channel
  import fgc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned CH_IDX  = 5,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = REG_W,
  parameter int unsigned PRE_W   = PDIV_W,
  parameter int unsigned FIN_W   = FDIV_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] ref_clk,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               cmd_enable,
  input  logic               cmd_disable,
  output logic               ch_enabled,
  output logic               clk_out
);
  logic [SEL_W-1:0] sel;
  logic             pre_gate;
  logic [PRE_W-1:0] pre_ratio;
  logic             fin_gate;
  logic [FIN_W-1:0] fin_ratio;
  logic             src_clk;
  logic             pre_in;
  logic             pre_out;
  logic             fin_in;

  fgc_regs #(
    .CH_IDX(CH_IDX), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PRE_W(PRE_W), .FIN_W(FIN_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .sel(sel), .pre_gate(pre_gate), .pre_ratio(pre_ratio),
    .fin_gate(fin_gate), .fin_ratio(fin_ratio)
  );

  fgc_xbar #(.NUM_SRC(NUM_SRC)) u_xbar (
    .ref_clk(ref_clk), .sel(sel), .clk_sel(src_clk)
  );

  fgc_icg u_pre_icg (
    .clk_in(src_clk), .rst_n(rst_n), .en_async(pre_gate), .clk_gated(pre_in)
  );

  fgc_div #(.W(PRE_W)) u_pre_div (
    .clk_in(pre_in), .rst_n(rst_n), .ratio_async(pre_ratio), .clk_div(pre_out)
  );

  fgc_icg u_fin_icg (
    .clk_in(pre_out), .rst_n(rst_n), .en_async(fin_gate), .clk_gated(fin_in)
  );

  fgc_div #(.W(FIN_W)) u_fin_div (
    .clk_in(fin_in), .rst_n(rst_n), .ratio_async(fin_ratio), .clk_div(clk_out)
  );

  assign ch_enabled = fin_gate;
endmodule

// File: rtl/fgc_channel_chk.sv
`timescale 1ns/1ps
module fgc_channel_chk
  import fgc_pkg::*;
#(
  parameter int unsigned CH_IDX = 5,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = REG_W,
  parameter int unsigned PRE_W  = PDIV_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              cmd_enable,
  input logic              cmd_disable,
  input logic              ch_enabled,
  input logic              pre_gate
);
  localparam logic [ADDR_W-1:0] XA =
    ADDR_W'(XBAR_BASE + (CH_IDX / LANES_PER_REG) * SLOT_STRIDE);
  localparam logic [ADDR_W-1:0] PA = ADDR_W'(PDIV_BASE + CH_IDX * SLOT_STRIDE);
  localparam logic [ADDR_W-1:0] FA = ADDR_W'(FDIV_BASE + CH_IDX * SLOT_STRIDE);

  wire unused_chk = ^reg_wdata;

  // R7
  dis_clears_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_disable |=> !ch_enabled);

  // R7
  en_opens_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_enable && !cmd_disable |=> ch_enabled && pre_gate);

  // R7
  dis_keeps_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_disable && !cmd_enable && !(reg_wr && reg_addr == XA) |=> pre_gate == $past(pre_gate));

  // R8
  fgate_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == FA && !cmd_enable && !cmd_disable |=> ch_enabled == $past(reg_wdata[FGATE_POS]));

  // R3
  pdiv_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == PA |-> reg_rdata[DATA_W-1:PRE_W] == '0);

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr != XA && reg_addr != PA && reg_addr != FA |-> reg_rdata == '0);

  // R10
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr != XA && reg_addr != PA && reg_addr != FA && !cmd_enable && !cmd_disable
      |=> $stable(ch_enabled) && $stable(pre_gate));
endmodule

bind fgc_channel fgc_channel_chk #(
  .CH_IDX(CH_IDX), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W)
) u_chk (.*);

// File: tb/tb_fgc_channel.sv
`timescale 1ns/1ps
module tb_fgc_channel;
  localparam real CLK_PERIOD = 10.0;
  localparam int  NSRC       = 64;
  localparam logic [11:0] A_XBAR = 12'h01C;  // channel 5: 0x18 + 4
  localparam logic [11:0] A_PDIV = 12'h06C;  // 0x58 + 20
  localparam logic [11:0] A_FDIV = 12'h178;  // 0x164 + 20

  typedef struct { real period; string req; } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] ref_clk;
  logic            reg_wr = 1'b0;
  logic [11:0]     reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            cmd_enable = 1'b0;
  logic            cmd_disable = 1'b0;
  logic            ch_enabled;
  logic            clk_out;

  int   n_checks = 0;
  int   n_errors = 0;
  int   rise_cnt = 0;
  int   runts = 0;
  real  last_edge = 0.0;
  exp_t exp_q[$];

  fgc_channel #(.NUM_SRC(NSRC), .CH_IDX(5)) dut (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .ch_enabled(ch_enabled), .clk_out(clk_out)
  );

  always #(CLK_PERIOD/2.0) clk = ~clk;

  // Source k has half-period 2+k ns, period 4+2k ns
  for (genvar k = 0; k < NSRC; k++) begin : g_ref
    logic r = 1'b0;
    initial forever #(2.0 + k) r = ~r;
    assign ref_clk[k] = r;
  end

  always @(posedge clk_out) rise_cnt++;

  // R9 runt watch: every phase at least the smallest half-period
  always @(clk_out) begin
    if (last_edge > 0.0 && ($realtime - last_edge) < 1.9) runts++;
    last_edge = $realtime;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(reg_rdata == e, req, $sformatf("read 0x%0h", a), reg_rdata, e);
  endtask

  task automatic pulse(input bit en, input bit dis);
    @(negedge clk);
    cmd_enable = en; cmd_disable = dis;
    @(negedge clk);
    cmd_enable = 1'b0; cmd_disable = 1'b0;
  endtask

  task automatic expect_period(input real p, input string req);
    exp_t e;
    e.period = p; e.req = req;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  task automatic quiet_chk(input string req);
    int e0;
    #1000;
    e0 = rise_cnt;
    #2000;
    check(rise_cnt == e0, req, "edges while gated", rise_cnt - e0, 0);
  endtask

  // Driver: disable, program with junk in foreign bits, read back, enable via final reg
  task automatic configure(input int s, input int p, input int f);
    logic [31:0] xw;
    pulse(1'b0, 1'b1);
    xw = 32'hFFFF_00FF | ((32'h80 | 32'h40 | 32'(s)) << 8);
    wr(A_XBAR, xw);
    wr(A_PDIV, 32'hFFFF_FC00 | 32'(p));
    wr(A_FDIV, 32'hFFFF_FF80 | 32'h40 | 32'(f));
    rd_chk(A_XBAR, (32'h40 | 32'(s)) << 8, "R2");
    rd_chk(A_PDIV, 32'(p), "R3");
    rd_chk(A_FDIV, 32'h40 | 32'(f), "R4");
    expect_period(real'((4 + 2*s) * (p + 1) * (f + 1)), "R5 R6");
  endtask

  // Monitor: skip settling edges, then compare one rise-to-rise period
  initial begin
    forever begin
      real t0;
      real d;
      wait (exp_q.size() > 0);
      repeat (5) @(posedge clk_out);
      t0 = $realtime;
      @(posedge clk_out);
      d = $realtime - t0;
      n_checks++;
      if (d < exp_q[0].period - 0.01 || d > exp_q[0].period + 0.01) begin
        n_errors++;
        $display("FAIL %s period: actual=%0.3f expected=%0.3f", exp_q[0].req, d, exp_q[0].period);
      end
      void'(exp_q.pop_front());
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(A_XBAR, 32'h0, "R1");
    rd_chk(A_PDIV, 32'h0, "R1");
    rd_chk(A_FDIV, 32'h0, "R1");
    check(ch_enabled == 1'b0, "R1", "ch_enabled", ch_enabled, 0);
    check(clk_out == 1'b0, "R1", "clk_out", clk_out, 0);
    quiet_chk("R1");

    // R5 R6 sweep of selects and ratios
    configure(0, 0, 0);
    configure(3, 2, 1);
    configure(10, 0, 4);
    configure(63, 1, 0);
    configure(7, 5, 3);
    configure(1, 1023, 0);
    configure(2, 0, 63);
    configure(3, 2, 1);

    // R7 R8 disable clears only the final gate
    pulse(1'b0, 1'b1);
    check(ch_enabled == 1'b0, "R8", "ch_enabled after disable", ch_enabled, 0);
    rd_chk(A_XBAR, 32'h43 << 8, "R7");
    rd_chk(A_FDIV, 32'h01, "R7");
    quiet_chk("R9");

    // R7 enable reopens, period resumes
    pulse(1'b1, 1'b0);
    check(ch_enabled == 1'b1, "R8", "ch_enabled after enable", ch_enabled, 1);
    rd_chk(A_FDIV, 32'h41, "R7");
    expect_period(60.0, "R7");

    // R7 R8 closing the pre gate stops output but keeps ch_enabled
    wr(A_XBAR, 32'h03 << 8);
    check(ch_enabled == 1'b1, "R8", "ch_enabled with pre gate off", ch_enabled, 1);
    quiet_chk("R7");
    pulse(1'b1, 1'b0);
    rd_chk(A_XBAR, 32'h43 << 8, "R7");
    expect_period(60.0, "R7");

    // R7 both commands together
    pulse(1'b1, 1'b1);
    check(ch_enabled == 1'b0, "R7", "final gate on both cmds", ch_enabled, 0);
    rd_chk(A_XBAR, 32'h43 << 8, "R7");

    // R10 foreign addresses
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h068, 32'hFFFF_FFFF);
    wr(12'h174, 32'hFFFF_FFFF);
    wr(12'h020, 32'hFFFF_FFFF);
    rd_chk(12'h018, 32'h0, "R10");
    rd_chk(12'h020, 32'h0, "R10");
    rd_chk(A_XBAR, 32'h43 << 8, "R10");
    rd_chk(A_PDIV, 32'h2, "R10");
    rd_chk(A_FDIV, 32'h01, "R10");
    check(ch_enabled == 1'b0, "R10", "ch_enabled after foreign writes", ch_enabled, 0);

    check(runts == 0, "R9", "runt phases", runts, 0);
    summary();
    $finish;
  end
endmodule